// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block sits after the floating-point datapath. It folds the IEEE exception flags that one operation raised into the floating-point status word. The operation presents its five raised flags together with the current status word and the program-counter pair. The block then decides whether the operation must trap, using the per-flag trap-enable field of that status word. From that decision it computes the new current-exception, accrued-exception and trap-type fields, and it either advances the program-counter pair or holds it.

On a trap, only the enabled flags count, and they are cut down to a single flag by a fixed priority. That single flag is reported as the current exception and nothing is accrued. Without a trap, every raised flag is reported as current and is also ORed into the accrued field. All results are registered and appear one clock cycle after the valid strobe. The trap indication is a one-cycle pulse.

Top module: `fp_exc_recorder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `stat_out`, `pc_out` and `npc_out` become zero and `trap_pulse` becomes 0.
- R2: An operation traps exactly when `op_flags & stat_in[27:23]` is nonzero. Field bit order is invalid=4, overflow=3, underflow=2, divide-by-zero=1, inexact=0.
- R3: On a trap, `stat_out[4:0]` holds exactly one bit: the highest-indexed bit of `op_flags & stat_in[27:23]`. The priority runs invalid, overflow, underflow, divide-by-zero, inexact.
- R4: Without a trap, `stat_out[4:0]` equals `op_flags`, replacing whatever `stat_in[4:0]` held.
- R5: Without a trap, `stat_out[9:5]` is `stat_in[9:5] | op_flags`. On a trap, it equals `stat_in[9:5]` unchanged.
- R6: `stat_out[16:14]` is 3'd1 on a trap and 3'd0 otherwise, whatever `stat_in[16:14]` held. Every other bit of `stat_out`, including the trap-enable field, equals the matching bit of `stat_in`.
- R7: On a trap, `pc_out` equals `pc_in` and `npc_out` equals `npc_in`.
- R8: Without a trap, `pc_out` equals `npc_in` and `npc_out` equals `npc_in + 4`, taken modulo 2^PC_W.
- R9: When `op_flags` is zero, no trap occurs, `stat_out[4:0]` becomes 0, the accrued field is unchanged, and the program-counter pair advances as in R8.
- R10: The outputs update on the clock edge that samples `op_valid` high. The outputs hold their values while `op_valid` is low. `trap_pulse` is high only in the cycle after a trapping operation was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | One operation's flags are presented this cycle |
| op_flags | input | 5 | Raised IEEE flags of the operation |
| pc_in | input | PC_W | Program counter of the operation |
| npc_in | input | PC_W | Next program counter |
| stat_in | input | STAT_W | Status word before the operation |
| stat_out | output | STAT_W | Updated status word |
| pc_out | output | PC_W | Updated program counter |
| npc_out | output | PC_W | Updated next program counter |
| trap_pulse | output | 1 | One-cycle pulse: the operation traps |

## Verification
Every combination of the 32 flag vectors and the 32 trap-enable masks is applied. This separates the three outcomes: no flags, flags with no enabled match (accrue and advance), and enabled matches (narrow and hold). It also covers every multi-flag case that the priority order must resolve. The stale current-exception, accrued and trap-type values, and the upper bits, vary from one vector to the next. That variation shows replacement versus ORing and the pass-through of untouched bits. A next-PC at the top of the address range checks the wrap. Idle cycles with changed inputs check that the outputs hold and that the trap pulse lasts a single cycle.

// File: rtl/fpx_pkg.sv
// Package fpx_pkg
// Field positions of the floating-point status word and the shared flag type.
// Assumes all fields fit in the status width chosen at the top.
package fpx_pkg;
    localparam int FLAG_W   = 5;
    localparam int CEXC_LO  = 0;
    localparam int AEXC_LO  = 5;
    localparam int TTYPE_LO = 14;
    localparam int TTYPE_W  = 3;
    localparam int TEM_LO   = 23;
    localparam logic [TTYPE_W-1:0] TTYPE_NONE = 3'd0;
    localparam logic [TTYPE_W-1:0] TTYPE_IEEE = 3'd1;
    typedef logic [FLAG_W-1:0] flags_t;
endpackage

// File: rtl/fpx_trap_decide.sv
// Module fpx_trap_decide
// Combinational trap decision and priority narrowing of the raised flags.
// Higher flag index means higher priority. Assumes flags and enables share bit order.
module fpx_trap_decide
    import fpx_pkg::*;
(
    input  flags_t raised,
    input  flags_t enables,
    output logic   trap,
    output flags_t eff_flags
);
    flags_t masked;
    flags_t single;

    // Purpose: keep only the raised flags whose trap is enabled.
    always_comb begin
        masked = raised & enables;
        trap   = |masked;
    end

    // Each bit survives only if no higher-priority enabled flag is raised.
    for (genvar i = 0; i < FLAG_W; i++) begin : g_prio
        if (i == FLAG_W - 1) begin : g_top
            assign single[i] = masked[i];
        end else begin : g_low
            assign single[i] = masked[i] & ~(|masked[FLAG_W-1:i+1]);
        end
    end

    // Purpose: pick the narrowed vector on a trap, the full vector otherwise.
    always_comb begin
        eff_flags = trap ? single : raised;
    end
endmodule

// File: rtl/fpx_status_merge.sv
// Module fpx_status_merge
// Builds the next status word: current field replaced, accrued field ORed
// only without trap, trap-type written, all other bits passed through.
module fpx_status_merge
    import fpx_pkg::*;
#(
    parameter int STAT_W = 32
)(
    input  logic [STAT_W-1:0] stat_cur,
    input  flags_t            eff_flags,
    input  logic              trap,
    output logic [STAT_W-1:0] stat_next
);
    // Purpose: compose the updated status fields.
    always_comb begin
        stat_next = stat_cur;
        stat_next[CEXC_LO +: FLAG_W] = eff_flags;
        if (!trap) begin
            stat_next[AEXC_LO +: FLAG_W] = stat_cur[AEXC_LO +: FLAG_W] | eff_flags;
        end
        stat_next[TTYPE_LO +: TTYPE_W] = trap ? TTYPE_IEEE : TTYPE_NONE;
    end
endmodule

// File: rtl/fpx_pc_step.sv
// Module fpx_pc_step
// Next program-counter pair: hold on a trap, otherwise step past the
// operation. The increment wraps modulo 2^PC_W.
module fpx_pc_step #(
    parameter int PC_W    = 64,
    parameter int STEP_SZ = 4
)(
    input  logic [PC_W-1:0] pc_cur,
    input  logic [PC_W-1:0] npc_cur,
    input  logic            hold,
    output logic [PC_W-1:0] pc_next,
    output logic [PC_W-1:0] npc_next
);
    localparam logic [PC_W-1:0] STEP = PC_W'(STEP_SZ);

    // Purpose: select the held or advanced pair.
    always_comb begin
        if (hold) begin
            pc_next  = pc_cur;
            npc_next = npc_cur;
        end else begin
            pc_next  = npc_cur;
            npc_next = npc_cur + STEP;
        end
    end
endmodule

// File: rtl/fp_exc_recorder.sv
// Module fp_exc_recorder
// Records one operation's IEEE flags into the status word and steps or holds
// the program-counter pair. All outputs are registered with one cycle latency.
// Assumes STAT_W covers the trap-enable field (STAT_W >= 28).
module fp_exc_recorder
    import fpx_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int PC_W   = 64
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_flags,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [PC_W-1:0]   npc_in,
    input  logic [STAT_W-1:0] stat_in,
    output logic [STAT_W-1:0] stat_out,
    output logic [PC_W-1:0]   pc_out,
    output logic [PC_W-1:0]   npc_out,
    output logic              trap_pulse
);
    flags_t            tem;
    flags_t            eff;
    logic              trap_now;
    logic [STAT_W-1:0] stat_nx;
    logic [PC_W-1:0]   pc_nx;
    logic [PC_W-1:0]   npc_nx;

    // Purpose: extract the trap-enable field.
    always_comb begin
        tem = stat_in[TEM_LO +: FLAG_W];
    end

    fpx_trap_decide u_decide (
        .raised    (op_flags),
        .enables   (tem),
        .trap      (trap_now),
        .eff_flags (eff)
    );

    fpx_status_merge #(.STAT_W(STAT_W)) u_merge (
        .stat_cur  (stat_in),
        .eff_flags (eff),
        .trap      (trap_now),
        .stat_next (stat_nx)
    );

    fpx_pc_step #(.PC_W(PC_W), .STEP_SZ(4)) u_step (
        .pc_cur   (pc_in),
        .npc_cur  (npc_in),
        .hold     (trap_now),
        .pc_next  (pc_nx),
        .npc_next (npc_nx)
    );

    // Purpose: register the results on an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_out   <= '0;
            pc_out     <= '0;
            npc_out    <= '0;
            trap_pulse <= 1'b0;
        end else begin
            trap_pulse <= op_valid & trap_now;
            if (op_valid) begin
                stat_out <= stat_nx;
                pc_out   <= pc_nx;
                npc_out  <= npc_nx;
            end
        end
    end

    AST_TRAP_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid) |-> (trap_pulse == ((($past(op_flags) & $past(stat_in[TEM_LO +: FLAG_W])) != 5'd0)))); // R2
    AST_TRAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> ($countones(stat_out[CEXC_LO +: FLAG_W]) == 1)); // R3
    AST_NO_ACCRUE_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (stat_out[AEXC_LO +: FLAG_W] == $past(stat_in[AEXC_LO +: FLAG_W]))); // R5
    AST_TTYPE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid) |-> (stat_out[TTYPE_LO +: TTYPE_W] == (trap_pulse ? 3'd1 : 3'd0))); // R6
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (pc_out == $past(pc_in) && npc_out == $past(npc_in))); // R7
    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_valid) && !trap_pulse) |-> (pc_out == $past(npc_in) && npc_out == $past(npc_in) + PC_W'(4))); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(op_valid) |-> (!trap_pulse && $stable(stat_out) && $stable(pc_out))); // R10
endmodule

// File: tb/fp_exc_recorder_tb.sv
module fp_exc_recorder_tb;
    localparam int STAT_W = 32;
    localparam int PC_W   = 64;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              op_valid;
    logic [4:0]        op_flags;
    logic [PC_W-1:0]   pc_in, npc_in;
    logic [STAT_W-1:0] stat_in;
    logic [STAT_W-1:0] stat_out;
    logic [PC_W-1:0]   pc_out, npc_out;
    logic              trap_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fp_exc_recorder #(.STAT_W(STAT_W), .PC_W(PC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_flags(op_flags),
        .pc_in(pc_in), .npc_in(npc_in), .stat_in(stat_in),
        .stat_out(stat_out), .pc_out(pc_out), .npc_out(npc_out),
        .trap_pulse(trap_pulse)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one operation and check the registered results.
    task automatic run_op(input logic [4:0] fl, input logic [4:0] tem, input int seed,
                          input logic [PC_W-1:0] npc_v);
        logic [STAT_W-1:0] s, es;
        logic [4:0] masked, eff;
        logic trap;
        s = 32'h5A3C_96E1 ^ (seed * 32'h9E37_79B9);
        s[27:23] = tem;
        masked = fl & tem;
        trap = (masked != 0);
        eff = fl;
        if (trap) begin
            eff = 0;
            for (int b = 4; b >= 0; b--) if (masked[b] && eff == 0) eff[b] = 1'b1;
        end
        es = s;
        es[4:0] = eff;
        if (!trap) es[9:5] = s[9:5] | fl;
        es[16:14] = trap ? 3'd1 : 3'd0;
        @(negedge clk);
        op_valid = 1'b1; op_flags = fl; stat_in = s;
        pc_in = npc_v - 64'd4; npc_in = npc_v;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R2 trap", {63'd0, trap_pulse}, {63'd0, trap});
        chk(trap ? "R3 cexc" : (fl == 0 ? "R9 cexc" : "R4 cexc"), {59'd0, stat_out[4:0]}, {59'd0, es[4:0]});
        chk("R5 aexc", {59'd0, stat_out[9:5]}, {59'd0, es[9:5]});
        chk("R6 rest", {32'd0, stat_out}, {32'd0, es});
        if (trap) begin
            chk("R7 pc", pc_out, npc_v - 64'd4);
            chk("R7 npc", npc_out, npc_v);
        end else begin
            chk(fl == 0 ? "R9 pc" : "R8 pc", pc_out, npc_v);
            chk("R8 npc", npc_out, npc_v + 64'd4);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [STAT_W-1:0] s_hold;
        logic [PC_W-1:0]   p_hold;
        rst_n = 1'b0; op_valid = 1'b0; op_flags = '0;
        pc_in = '1; npc_in = '1; stat_in = '1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 stat", {32'd0, stat_out}, 64'd0);
        chk("R1 pc", pc_out, 64'd0);
        chk("R1 npc", npc_out, 64'd0);
        chk("R1 trap", {63'd0, trap_pulse}, 64'd0);
        rst_n = 1'b1;
        // Full sweep of flags and enables.
        for (int t = 0; t < 32; t++) begin
            for (int f = 0; f < 32; f++) begin
                run_op(5'(f), 5'(t), t * 32 + f, 64'h0000_0040_0000_1000 + 64'(t * 256 + f * 8));
            end
        end
        // R8: wrap of the next-PC increment.
        run_op(5'b00001, 5'b00000, 7, 64'hFFFF_FFFF_FFFF_FFFC);
        // R10: outputs hold while idle, trap pulse lasts one cycle.
        run_op(5'b10001, 5'b10000, 9, 64'h0000_0000_0000_2000);
        s_hold = stat_out; p_hold = pc_out;
        stat_in = 32'h0; op_flags = 5'b11111; pc_in = 64'd0; npc_in = 64'd0;
        @(negedge clk);
        chk("R10 trap one cycle", {63'd0, trap_pulse}, 64'd0);
        chk("R10 stat hold", {32'd0, stat_out}, {32'd0, s_hold});
        chk("R10 pc hold", pc_out, p_hold);
        @(negedge clk);
        chk("R10 stat hold 2", {32'd0, stat_out}, {32'd0, s_hold});
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule